// File: doc/BRIEF.md
# Configurable external interrupt sense unit

This block watches a small set of external interrupt lines and turns their activity into one interrupt request for a processor. Each line has its own two-bit sense mode: low level, any change, falling edge or rising edge. Every line is brought into the system clock domain through a two-stage synchroniser. Edges are found by comparing the synchronised sample with the sample taken one clock earlier. A detected edge sets a sticky per-line flag. The flag stays set until software writes a 1 to it, or until the interrupt for that line is acknowledged. In low-level mode nothing is stored, and the request follows the sampled line directly.

Per-line mask bits and a global enable input gate the pending lines onto a single request output. An encoded identifier names the lowest-numbered line among those being requested. The block looks only at the sampled value of each pin. Software can therefore raise an interrupt by driving a line itself.

A small register port exposes the sense control, the mask and the flags. A separate wake-up qualifier samples the raw lines on a slow auxiliary clock. It raises a wake signal when a masked low-level line has been seen low on two slow samples in a row, whatever the global enable is.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense control, mask and flag registers read zero, and `irq` and `wake` are low.
- R2: Register address 0 holds the sense control, with line n in bits [2n+1:2n]. Address 1 holds the mask in bits [3:0]. Address 2 holds the flags in bits [3:0]. Reads are combinational, and any other address reads zero.
- R3: Sense code 00 makes a line pending while its sampled value is low. The line's flag stays 0 in this mode, so the request drops once the line is sampled high.
- R4: Sense code 10 sets the line's flag on a high-to-low sample transition. Code 11 sets it on a low-to-high transition. The opposite transition leaves the flag unchanged.
- R5: Sense code 01 sets the line's flag on a transition in either direction.
- R6: A set flag stays set while its line changes, until it is cleared. Writing to address 2 clears each flag whose write-data bit is 1. A flag set by an edge in the same cycle as a clear stays set.
- R7: `irq` is high exactly when `gie` is high and at least one line is both pending and unmasked.
- R8: `irq_id` gives the lowest-numbered line that is pending and unmasked.
- R9: A one-cycle `irq_ack` while `irq` is high clears the flag of the line named by `irq_id`. An `irq_ack` while `irq` is low clears nothing.
- R10: Writing the sense control never sets a flag by itself, even while a line is held low.
- R11: In level mode a line change reaches `irq` on the second rising clock edge after the change. An edge flag is set on the third.
- R12: `wake` rises when a masked line in sense code 00 has been low on two consecutive `slow_clk` rising edges, whatever `gie` is. It falls after the first `slow_clk` edge that samples that line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow auxiliary clock for the wake-up qualifier |
| line_in | input | 4 | External interrupt lines |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge of the currently requested line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Combined interrupt request |
| irq_id | output | 2 | Lowest-numbered requesting line |
| wake | output | 1 | Wake-up request from the slow-clock qualifier |

## Verification
A corrupted edge history or sense field shows up as a flag bit that appears, or fails to appear, in the flag register three clock edges after a line change, so the flag readback finds it within a few cycles. A stuck flag shows up as `irq` and `irq_id` that do not move after a clear or an acknowledge, and is visible on the very next cycle. A broken synchroniser depth shows up as level-mode `irq` changing one edge early or late. The wake qualifier is checked slow sample by slow sample: a wrong depth there changes which slow edge raises `wake`.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NLINES = 4,
  parameter int DW     = 8,
  localparam int IDW   = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int CW    = 2 * NLINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic [NLINES-1:0] line_in,
  input  logic              gie,
  input  logic              irq_ack,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic [IDW-1:0]    irq_id,
  output logic              wake
);

  localparam logic [1:0] MD_LOW  = 2'b00;
  localparam logic [1:0] MD_ANY  = 2'b01;
  localparam logic [1:0] MD_FALL = 2'b10;
  localparam logic [1:0] MD_RISE = 2'b11;

  logic [CW-1:0]     sense_q;
  logic [NLINES-1:0] mask_q, flag_q;
  logic [NLINES-1:0] sync1, smp, hist;
  logic [NLINES-1:0] ws1, ws2;
  logic [NLINES-1:0] edge_hit, pend, req, w1c, ack_clr, lvl_en;
  logic              ctrl_wr;

  assign ctrl_wr = reg_we && reg_addr == 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '1;
      smp   <= '1;
      hist  <= '1;
    end else begin
      sync1 <= line_in;
      smp   <= sync1;
      hist  <= smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == 2'd0) sense_q <= reg_wdata[CW-1:0];
      if (reg_addr == 2'd1) mask_q  <= reg_wdata[NLINES-1:0];
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [1:0] md;
    assign md = sense_q[2*i +: 2];

    assign edge_hit[i] = (md == MD_ANY  && smp[i] != hist[i]) ||
                         (md == MD_FALL && !smp[i] && hist[i]) ||
                         (md == MD_RISE && smp[i] && !hist[i]);
    assign pend[i]    = (md == MD_LOW) ? !smp[i] : flag_q[i];
    assign w1c[i]     = reg_we && reg_addr == 2'd2 && reg_wdata[i];
    assign ack_clr[i] = irq_ack && irq && irq_id == IDW'(i);
    assign lvl_en[i]  = mask_q[i] && md == MD_LOW;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (ctrl_wr && reg_wdata[2*i +: 2] == MD_LOW)
        flag_q[i] <= 1'b0;
      else if (edge_hit[i])
        flag_q[i] <= 1'b1;
      else if (w1c[i] || ack_clr[i])
        flag_q[i] <= 1'b0;
    end

    assert_level_unlatched_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (md == MD_LOW) |-> !flag_q[i]);

    assert_flag_has_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(smp[i] != hist[i]));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(w1c[i] || ack_clr[i] || ctrl_wr));
  end

  assign req = pend & mask_q;
  assign irq = gie && |req;

  always_comb begin
    irq_id = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (req[i]) irq_id = IDW'(i);
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[CW-1:0]     = sense_q;
      2'd1:    reg_rdata[NLINES-1:0] = mask_q;
      2'd2:    reg_rdata[NLINES-1:0] = flag_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      ws1 <= '1;
      ws2 <= '1;
    end else begin
      ws1 <= line_in;
      ws2 <= ws1;
    end
  end

  assign wake = |(lvl_en & ~ws1 & ~ws2);

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);

  assert_id_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> req[irq_id]);

  assert_id_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((req & ~({NLINES{1'b1}} << irq_id)) == '0));

endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  localparam int CLK_P  = 10;
  localparam int SLOW_P = 80;

  logic       clk = 0, slow_clk = 0, rst_n = 0;
  logic [3:0] line_in = 4'hF;
  logic       gie = 0, irq_ack = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq, wake;
  logic [1:0] irq_id;

  int checks = 0, errors = 0;
  bit done = 0;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .line_in(line_in),
    .gie(gie), .irq_ack(irq_ack), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .irq_id(irq_id), .wake(wake));

  always #(CLK_P/2) clk = ~clk;
  always #(SLOW_P/2) slow_clk = ~slow_clk;

  // {mask[3:0], gie, line_in[3:0], exp_irq, exp_id[1:0]}, all lines in level mode
  localparam logic [11:0] VEC [7] = '{
    12'b1111_1_1111_0_00,
    12'b1111_1_1110_1_00,
    12'b1111_1_0011_1_10,
    12'b0011_1_0011_0_00,
    12'b1100_0_0000_0_00,
    12'b1100_1_0000_1_10,
    12'b1000_1_0000_1_11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(0, d); chk("R1 ctrl reset", d, 0);
    rd(1, d); chk("R1 mask reset", d, 0);
    rd(2, d); chk("R1 flag reset", d, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 wake reset", wake, 0);
    rd(3, d); chk("R2 unused address", d, 0);

    for (int k = 0; k < 7; k++) begin
      wr(1, {4'h0, VEC[k][11:8]});
      gie = VEC[k][7];
      line_in = VEC[k][6:3];
      settle(4);
      chk("R7 level irq", irq, VEC[k][2]);
      if (VEC[k][2]) chk("R8 level id", irq_id, VEC[k][1:0]);
      rd(2, d); chk("R3 no level flag", d, 0);
    end

    wr(1, 8'h0F); gie = 1; line_in = 4'hF; settle(4);
    rd(1, d); chk("R2 mask readback", d, 8'h0F);
    line_in = 4'hE;
    @(posedge clk); @(negedge clk);
    chk("R11 one edge", irq, 0);
    @(posedge clk); @(negedge clk);
    chk("R11 two edges", irq, 1);
    line_in = 4'hF; settle(3);
    chk("R3 level released", irq, 0);

    line_in = 4'hC; settle(4);
    wr(1, 8'h07);
    wr(0, 8'h1E);
    rd(0, d); chk("R2 ctrl readback", d, 8'h1E);
    settle(4);
    rd(2, d); chk("R10 no false edge", d, 0);

    line_in = 4'hE;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2, d); chk("R11 flag not yet", d, 0);
    @(posedge clk); @(negedge clk);
    rd(2, d); chk("R11 flag on third", d, 8'h02);
    settle(2);
    rd(2, d); chk("R4 rising sets", d, 8'h02);
    chk("R8 id rising", irq_id, 1);
    line_in = 4'hF; settle(4);
    rd(2, d); chk("R4 rise on falling line", d, 8'h02);
    line_in = 4'hE; settle(4);
    rd(2, d); chk("R4 falling sets", d, 8'h03);
    chk("R8 lowest wins", irq_id, 0);
    pulse_ack(); @(negedge clk);
    rd(2, d); chk("R9 ack clears", d, 8'h02);
    chk("R9 next id", irq_id, 1);
    line_in = 4'hC; settle(4);
    rd(2, d); chk("R6 sticky", d, 8'h02);

    gie = 0;
    pulse_ack(); @(negedge clk);
    rd(2, d); chk("R9 ack without irq", d, 8'h02);
    gie = 1;
    wr(2, 8'h02); @(negedge clk);
    rd(2, d); chk("R6 w1c", d, 0);
    chk("R7 irq after clear", irq, 0);

    line_in = 4'h8; settle(4);
    rd(2, d); chk("R5 any fall", d, 8'h04);
    chk("R8 id any", irq_id, 2);
    wr(2, 8'h04); @(negedge clk);
    rd(2, d); chk("R6 w1c any", d, 0);
    line_in = 4'hC; settle(4);
    rd(2, d); chk("R5 any rise", d, 8'h04);

    wr(0, 8'h00);
    rd(2, d); chk("R3 level mode clears", d, 0);
    wr(1, 8'h01); gie = 0; line_in = 4'hF;
    @(negedge slow_clk); @(negedge slow_clk);
    line_in = 4'hE;
    @(posedge slow_clk); #1;
    chk("R12 one sample", wake, 0);
    @(posedge slow_clk); #1;
    chk("R12 two samples", wake, 1);
    chk("R7 no irq gie off", irq, 0);
    @(negedge slow_clk);
    line_in = 4'hF;
    @(posedge slow_clk); #1;
    chk("R12 release", wake, 0);
    wr(1, 8'h00);
    @(negedge slow_clk);
    line_in = 4'hE;
    @(posedge slow_clk); @(posedge slow_clk); @(posedge slow_clk); #1;
    chk("R12 masked", wake, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule